// File: doc/BRIEF.md
# Predicate counter-to-mask pair extractor

This unit carries out the "extract pair" step of a vector predicate pipeline. It takes a 16-bit predicate held in counter form and expands it into a byte-granular mask as wide as four predicate registers. From that mask it picks one of two register-sized portion pairs, re-spaces the chosen elements to the element size of the operation, and presents the two results together with the indices of the destination register pair they belong to. Every register-file access is left to the surrounding pipeline. The unit only drives the read address for the source register and receives the counter bits that are read back.

The operation is accepted on a single-cycle `in_valid` strobe. Expansion and selection are combinational. Results, destination indices and a one-cycle `out_done` pulse appear on the clock edge after the strobe. The vector length `VLEN` is a parameter and must be a multiple of 128 in the range 128 to 2048. In the requirements, the predicate width is PL = VLEN/8 bits and the mask width is 4·PL bits. Predicate bit j stands for byte j of a vector.

Top module: `pred_pair_extract`

## Requirements
- R1: `size` selects the element width as 8<<size bits (0 = byte, 1 = halfword, 2 = word, 3 = doubleword). Each element spans 2^size predicate bits. In `out_res0` and `out_res1`, every bit whose index is not a multiple of 2^size is 0.
- R2: `src_addr` equals {1'b1, `src_sel`} combinationally, so only registers 8 to 15 can be read.
- R3: On the edge after a strobe, `out_dst0` equals `dst_idx` and `out_dst1` equals (`dst_idx`+1) mod 16. An index of 15 therefore pairs with 0.
- R4: The counter's element width comes from the lowest set bit k of `cnt[3:0]`: 2^k bytes per counter element. The active count is `cnt[14:0]` >> (k+1).
- R5: With `cnt[15]`=0, the lowest `count` counter elements of the mask are active. With `cnt[15]`=1, the highest `count` counter elements are active. An active element sets only the mask bit at its lowest byte.
- R6: The count saturates at the number of counter elements in the mask, (VLEN/2) >> k.
- R7: When `cnt[3:0]` is 0, the mask and both results are all zero, whatever the other counter bits hold.
- R8: Predicate bit j of `out_res0` is mask bit (part·2·PL + j), and predicate bit j of `out_res1` is mask bit (part·2·PL + PL + j), for bits j that are multiples of 2^size.
- R9: `out_done` is high exactly on the cycle after each strobe. Without a strobe, the results and indices hold their previous values.
- R10: After reset, `out_done` is 0 and all indices and results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| size | input | 2 | Element size code |
| src_sel | input | 3 | Low bits of the source register index |
| dst_idx | input | 4 | First destination register index |
| part | input | 1 | Portion pair select |
| cnt | input | 16 | Counter-form predicate read from the source |
| src_addr | output | 4 | Source register read address |
| out_done | output | 1 | Result valid pulse |
| out_dst0 | output | 4 | First destination index |
| out_dst1 | output | 4 | Second destination index |
| out_res0 | output | VLEN/8 | Result for the first destination |
| out_res1 | output | VLEN/8 | Result for the second destination |

## Verification
The assertions assume that the counter bits, size and portion are meaningful only in the strobe cycle, and that the caller treats registered outputs as data only when `out_done` is high. The bench therefore changes these inputs freely between strobes, and it also runs idle cycles with random values on them to show that the outputs hold. The stimulus builds every counter from a chosen element-size bit, a count and an invert flag, so the count always fits the field above the size bit. Counts run past the saturation point, and separate vectors cover a zero low nibble with junk in the upper bits.

// File: rtl/pred_pair_extract.sv
module pred_pair_extract #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        size,
  input  logic [2:0]        src_sel,
  input  logic [3:0]        dst_idx,
  input  logic              part,
  input  logic [15:0]       cnt,
  output logic [3:0]        src_addr,
  output logic              out_done,
  output logic [3:0]        out_dst0,
  output logic [3:0]        out_dst1,
  output logic [VLEN/8-1:0] out_res0,
  output logic [VLEN/8-1:0] out_res1
);
  localparam int PL = VLEN / 8;
  localparam int MW = 4 * PL;

  assign src_addr = {1'b1, src_sel};

  logic        c_live;
  logic [1:0]  c_k;
  logic [14:0] c_field, c_elems, c_sat, c_lo, c_hi;
  logic [MW-1:0] mask;
  logic [PL-1:0] r0, r1;

  assign c_live  = |cnt[3:0];
  assign c_k     = cnt[0] ? 2'd0 : cnt[1] ? 2'd1 : cnt[2] ? 2'd2 : 2'd3;
  assign c_field = cnt[14:0] >> ({1'b0, c_k} + 3'd1);
  assign c_elems = 15'(MW) >> c_k;
  assign c_sat   = (c_field > c_elems) ? c_elems : c_field;
  assign c_lo    = cnt[15] ? c_elems - c_sat : 15'd0;
  assign c_hi    = cnt[15] ? c_elems : c_sat;

  always_comb begin
    for (int j = 0; j < MW; j++) begin
      logic [14:0] m;
      logic        lead;
      m = 15'(j) >> c_k;
      lead = (15'(j) & ((15'd1 << c_k) - 15'd1)) == 15'd0;
      mask[j] = c_live && lead && (m >= c_lo) && (m < c_hi);
    end
  end

  always_comb begin
    for (int j = 0; j < PL; j++) begin
      logic lead;
      int   base;
      base = part ? 2 * PL : 0;
      lead = (j & ((1 << size) - 1)) == 0;
      r0[j] = lead & mask[base + j];
      r1[j] = lead & mask[base + PL + j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done <= 1'b0;
      out_dst0 <= '0;
      out_dst1 <= '0;
      out_res0 <= '0;
      out_res1 <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_dst0 <= dst_idx;
        out_dst1 <= dst_idx + 4'd1;
        out_res0 <= r0;
        out_res1 <= r1;
      end
    end
  end
endmodule

// File: rtl/pred_pair_extract_chk.sv
module pred_pair_extract_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        size,
  input logic [3:0]        dst_idx,
  input logic [15:0]       cnt,
  input logic              out_done,
  input logic [3:0]        out_dst0,
  input logic [3:0]        out_dst1,
  input logic [VLEN/8-1:0] out_res0,
  input logic [VLEN/8-1:0] out_res1
);
  localparam int PL = VLEN / 8;

  function automatic logic [PL-1:0] leads(input logic [1:0] sz);
    for (int j = 0; j < PL; j++) leads[j] = (j % (1 << sz)) == 0;
  endfunction

  // R9
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_res0) && $stable(out_res1) && $stable(out_dst0));
  // R3
  dst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_dst0 == $past(dst_idx) && out_dst1 == 4'($past(dst_idx) + 4'd1));
  // R1
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_res0 | out_res1) & ~leads($past(size))) == '0);
  // R7
  empty_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cnt[3:0] == 4'd0 |=> out_res0 == '0 && out_res1 == '0);
endmodule

bind pred_pair_extract pred_pair_extract_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size(size), .dst_idx(dst_idx),
  .cnt(cnt), .out_done(out_done), .out_dst0(out_dst0), .out_dst1(out_dst1),
  .out_res0(out_res0), .out_res1(out_res1));

// File: tb/tb_pred_pair_extract.sv
module tb_pred_pair_extract;
  localparam int VLEN = 256;
  localparam int PL = VLEN / 8;
  localparam int MW = 4 * PL;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, part = 0;
  logic [1:0] size = 0;
  logic [2:0] src_sel = 0;
  logic [3:0] dst_idx = 0;
  logic [15:0] cnt = 0;
  logic [3:0] src_addr, out_dst0, out_dst1;
  logic out_done;
  logic [PL-1:0] out_res0, out_res1;

  pred_pair_extract #(.VLEN(VLEN)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  bit ended = 0;
  logic e_done = 0;
  logic [3:0] e_d0 = 0, e_d1 = 0;
  logic [PL-1:0] e_r0 = 0, e_r1 = 0;

  task automatic model(input logic [1:0] sz, input logic pt, input logic [15:0] c,
                       output logic [PL-1:0] r0, output logic [PL-1:0] r1);
    bit [MW-1:0] mk = '0;
    int k, eb, total, n, elems, ps;
    if (c[3:0] != 0) begin
      k = 0;
      while (!c[k]) k++;
      eb = 1 << k;
      total = MW / eb;
      n = int'(c[14:0]) >> (k + 1);
      if (n > total) n = total;
      for (int m = 0; m < total; m++)
        if (c[15] ? (m >= total - n) : (m < n)) mk[m * eb] = 1;
    end
    ps = 1 << sz;
    elems = PL / ps;
    r0 = '0; r1 = '0;
    for (int e = 0; e < elems; e++) begin
      r0[e * ps] = mk[(pt * 2 * elems + e) * ps];
      r1[e * ps] = mk[(pt * 2 * elems + elems + e) * ps];
    end
  endtask

  task automatic step(input logic v, input logic [1:0] sz, input logic [3:0] di,
                      input logic pt, input logic [15:0] c, input string tag);
    logic [2:0] ss;
    ss = 3'($urandom);
    in_valid = v; size = sz; dst_idx = di; part = pt; cnt = c; src_sel = ss;
    #1;
    vectors++;
    if (src_addr !== {1'b1, ss}) begin
      fails++; $display("FAIL R2: src_addr got %h exp %h", src_addr, {1'b1, ss});
    end
    e_done = v;
    if (v) begin
      e_d0 = di; e_d1 = di + 4'd1;
      model(sz, pt, c, e_r0, e_r1);
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (out_done !== e_done) begin
      fails++; $display("FAIL R9: done got %b exp %b", out_done, e_done);
    end
    if (out_dst0 !== e_d0 || out_dst1 !== e_d1) begin
      fails++; $display("FAIL R3: dst got %h/%h exp %h/%h", out_dst0, out_dst1, e_d0, e_d1);
    end
    if (out_res0 !== e_r0 || out_res1 !== e_r1) begin
      fails++; $display("FAIL %s: res got %h/%h exp %h/%h", tag, out_res0, out_res1, e_r0, e_r1);
    end
  endtask

  function automatic logic [15:0] mkc(input bit inv, input int k, input int n);
    int lim;
    lim = (1 << (14 - k)) - 1;
    if (n > lim) n = lim;
    return {inv, 15'((n << (k + 1)) | (1 << k))};
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R9: watchdog got hang exp completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (out_done !== 0 || out_dst0 !== 0 || out_dst1 !== 0 || out_res0 !== 0 || out_res1 !== 0) begin
      fails++; $display("FAIL R10: reset got %b %h %h %h %h exp all zero",
                        out_done, out_dst0, out_dst1, out_res0, out_res1);
    end
    rst_n = 1;
    // R4: bottom-anchored counts per counter element size
    for (int k = 0; k < 4; k++)
      for (int n = 0; n <= 20; n++) step(1, 2'd0, 4'd2, 0, mkc(0, k, n), "R4");
    // R5: inverted, top-anchored, both portions
    for (int k = 0; k < 4; k++)
      for (int n = 0; n <= 40; n += 3) begin
        step(1, 2'd0, 4'd4, 1, mkc(1, k, n), "R5");
        step(1, 2'd0, 4'd4, 0, mkc(1, k, n * 2), "R5");
      end
    // R6: saturation at and beyond the mask's element count
    for (int k = 0; k < 4; k++)
      for (int d = -1; d <= 3; d++)
        for (int inv = 0; inv < 2; inv++) begin
          step(1, 2'd0, 4'd6, 0, mkc(inv[0], k, ((MW >> k) + d * 7)), "R6");
          step(1, 2'd0, 4'd6, 1, mkc(inv[0], k, 16383), "R6");
        end
    // R1: every element size against every counter size
    for (int sz = 0; sz < 4; sz++)
      for (int k = 0; k < 4; k++)
        for (int n = 1; n < MW; n += 9) step(1, 2'(sz), 4'd8, 0, mkc(0, k, n), "R1");
    // R8: portion selection across sizes and senses
    for (int sz = 0; sz < 4; sz++)
      for (int pt = 0; pt < 2; pt++)
        for (int inv = 0; inv < 2; inv++)
          for (int k = 0; k < 4; k++)
            for (int n = 0; n <= MW; n += 13)
              step(1, 2'(sz), 4'(n), pt[0], mkc(inv[0], k, n), "R8");
    // R7: empty size nibble with junk above
    for (int i = 0; i < 40; i++)
      step(1, 2'($urandom), 4'd1, 1'($urandom), {12'($urandom), 4'd0}, "R7");
    // R3: full destination sweep including the wrap
    for (int d = 0; d < 16; d++) step(1, 2'd1, 4'(d), 0, mkc(0, 0, 50), "R3");
    // R9: idle cycles hold, then back-to-back strobes
    for (int i = 0; i < 30; i++) begin
      step(1, 2'($urandom), 4'($urandom), 1'($urandom), mkc(1'($urandom), i % 4, i * 3), "R9");
      step(0, 2'($urandom), 4'($urandom), 1'($urandom), 16'($urandom), "R9");
      step(0, 2'($urandom), 4'($urandom), 1'($urandom), 16'($urandom), "R9");
    end
    for (int i = 0; i < 200; i++)
      step(1, 2'($urandom), 4'($urandom), 1'($urandom), mkc(1'($urandom), i % 4, $urandom % 300), "R9");
    step(0, 2'd0, 4'd0, 0, 16'd0, "R9");
    summary();
  end
endmodule